// File: doc/BRIEF.md
# Serial Control and Status Shift Port

This block is the serial slave front end of a twelve-channel load driver. A host frames each transfer with an active-low chip select. While the select is low, the host clocks in a 16-bit control word on the serial data input. At the same time the block clocks out a 16-bit status word on the serial data output. Both words travel least significant bit first. The control word reaches the driver only when the select rises after a complete word. Short or overlong frames are thrown away. This lets a host pull select low, read the first status bit (the temperature prewarning), and release select again without disturbing anything.

All serial pins are sampled by the block's system clock through a synchronizer chain, and their edges are found in that clock domain. The serial clock must therefore run well below the system clock. Every serial phase must last at least SYNC_STAGES+3 system cycles. Control word layout, which downstream logic decodes by position:
- bit 0: reset request for the protection flags
- bits 1..12: channel enables in the order low-side 1, high-side 1, low-side 2, and so on up to high-side 6
- bit 13: open-load detection, active low
- bit 14: delay select
- bit 15: run, where low means inhibit

Status word layout:
- bit 0: temperature prewarning
- bits 1..12: per-channel state in the same order
- bit 13: short-circuit flag
- bit 14: inhibit state
- bit 15: supply fault

The status sources lie outside this block and arrive as a parallel word. Control and status are plain level pins with no handshake. The parallel status word is sampled at frame start. The control word is a held register.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset, ctrl_word is 16'hE000 (bits 15, 14 and 13 high, all others low). In the same state sdo_oe is low and sreset_pulse is low.
- R2: sdo_oe is high while the synchronized cs_n is low and low while it is high. sdo is 0 whenever sdo_oe is low.
- R3: On the falling edge of cs_n, stat_word is captured. Its bit 0 appears on sdo before any sclk edge.
- R4: The first rising sclk edge of a frame keeps bit 0 on sdo. Each later rising edge advances sdo by one bit. sdo holds between rising edges. As a result, at the k-th falling sclk edge (k = 1..16) sdo carries status bit k-1.
- R5: sdi is sampled on each falling sclk edge while cs_n is low. The first sampled bit becomes bit 0 of the received word.
- R6: On the rising edge of cs_n, if exactly 16 falling sclk edges occurred in the frame, ctrl_word takes the received word with bit 0 forced to 0. ctrl_word changes at no other time.
- R7: A frame with any other number of falling sclk edges (0, 15, 17) leaves ctrl_word unchanged.
- R8: A committed word with bit 0 high produces sreset_pulse high for exactly one clock cycle. A committed word with bit 0 low produces no pulse.
- R9: Changes on stat_word after the falling edge of cs_n do not alter the bits shifted out in that frame.
- R10: sclk and sdi activity while cs_n is high has no effect on ctrl_word, on the next frame's received word, or on its output order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in, LSB first |
| stat_word | input | 16 | Parallel status word from protection logic |
| sdo | output | 1 | Serial data out, LSB first |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| ctrl_word | output | 16 | Committed control word, bit 0 always 0 |
| sreset_pulse | output | 1 | One-cycle flag-reset request |

## Verification
The hardest situations to reach are frames that end at the wrong moment: a select that rises after zero, fifteen or seventeen clocks, and serial clock activity while deselected. These must all leave the control register exactly as it was. The stimulus builds frames with a chosen clock count and a known prior register value, and it toggles the serial clock and data before a later full frame. It also changes the parallel status word in the middle of a frame, so that any late re-sampling shows up in the bits read back.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
  localparam int unsigned WORD_BITS = 16;
  localparam logic [WORD_BITS-1:0] CTRL_POR = 16'hE000;
  localparam int unsigned FLAG_RESET_BIT = 0;

  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic cs_low;
    logic sck_rise;
    logic sck_fall;
    logic din;
  } ser_evt_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int unsigned N_BITS = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N_BITS-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] d,
  output logic [N_BITS-1:0] q
);
  logic [N_BITS-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_edges.sv
module scp_edges
  import serial_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_s,
  input  logic     sck_s,
  input  logic     din_s,
  output ser_evt_t ev
);
  logic cs_d, sck_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end

  always_comb begin
    ev.cs_fall  = cs_d & ~cs_s;
    ev.cs_rise  = ~cs_d & cs_s;
    ev.cs_low   = ~cs_s;
    ev.sck_rise = ~sck_d & sck_s & ~cs_s;
    ev.sck_fall = sck_d & ~sck_s & ~cs_s;
    ev.din      = din_s;
  end
endmodule

// File: rtl/scp_rx.sv
module scp_rx
  import serial_ctl_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned CNT_W = $clog2(W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ser_evt_t         ev,
  output logic [W-1:0]     word,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(W + 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word  <= '0;
      count <= '0;
    end else if (ev.cs_fall) begin
      word  <= '0;
      count <= '0;
    end else if (ev.sck_fall) begin
      word <= {ev.din, word[W-1:1]};
      if (count != CNT_SAT) count <= count + 1'b1;
    end

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.cs_low |=> $stable(word) && $stable(count));
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_SAT);
endmodule

// File: rtl/scp_tx.sv
module scp_tx
  import serial_ctl_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ser_evt_t     ev,
  input  logic [W-1:0] stat,
  output logic         sdo,
  output logic         sdo_oe
);
  logic [W-1:0] shreg;
  logic         first_seen;
  logic         oe_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg      <= '0;
      first_seen <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      oe_q <= ev.cs_low;
      if (ev.cs_fall) begin
        shreg      <= stat;
        first_seen <= 1'b0;
      end else if (ev.sck_rise) begin
        if (first_seen) shreg <= {1'b0, shreg[W-1:1]};
        else            first_seen <= 1'b1;
      end
    end

  assign sdo_oe = oe_q;
  assign sdo    = oe_q & shreg[0];

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  assert_bit0_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cs_fall |=> sdo == $past(stat[0]));
  assert_hold_between_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !ev.sck_rise && !ev.cs_fall && !ev.cs_rise) |=> $stable(sdo));
endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
  import serial_ctl_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_BITS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] CTRL_RESET = CTRL_POR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [WORD_W-1:0] stat_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              sreset_pulse
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [2:0]        pins_s;
  ser_evt_t          ev;
  logic [WORD_W-1:0] rx_word;
  logic [CNT_W-1:0]  rx_count;
  logic [WORD_W-1:0] ctrl_q;
  logic              pulse_q;
  logic              commit;

  scp_sync #(.N_BITS(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s));

  scp_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cs_s(pins_s[2]), .sck_s(pins_s[1]),
    .din_s(pins_s[0]), .ev(ev));

  scp_rx #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ev(ev), .word(rx_word), .count(rx_count));

  scp_tx #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .ev(ev), .stat(stat_word),
    .sdo(sdo), .sdo_oe(sdo_oe));

  assign commit = ev.cs_rise && (rx_count == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET & ~(WORD_W'(1) << FLAG_RESET_BIT);
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= commit & rx_word[FLAG_RESET_BIT];
      if (commit) begin
        ctrl_q <= rx_word;
        ctrl_q[FLAG_RESET_BIT] <= 1'b0;
      end
    end

  assign ctrl_word    = ctrl_q;
  assign sreset_pulse = pulse_q;

  assert_commit_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(ev.cs_rise && rx_count == CNT_FULL));
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_pulse |=> !sreset_pulse);
  assert_pulse_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_pulse |-> $past(ev.cs_rise));
endmodule

// File: tb/serial_ctl_port_tb.sv
module serial_ctl_port_tb;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] stat_word = 16'h0000;
  logic sdo, sdo_oe, sreset_pulse;
  logic [15:0] ctrl_word;

  int checks = 0, failures = 0;
  int pulse_cnt = 0, pulse_long = 0;
  logic pulse_prev = 1'b0;
  logic [15:0] exp_ctrl;
  int exp_pulses = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_ctl_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .stat_word(stat_word), .sdo(sdo), .sdo_oe(sdo_oe),
    .ctrl_word(ctrl_word), .sreset_pulse(sreset_pulse));

  always @(posedge clk) begin
    if (sreset_pulse) pulse_cnt++;
    if (sreset_pulse && pulse_prev) pulse_long++;
    pulse_prev <= sreset_pulse;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference: full frame of n clocks sending word, returning read bits
  task automatic frame(input logic [15:0] word, input int n, input logic [15:0] st,
                       input bit swap_status, output logic [15:0] rd, output int rd_err);
    rd = '0; rd_err = 0;
    stat_word = st;
    cs_n = 1'b0;
    wait_cyc(HALF);
    if (swap_status) stat_word = ~st;
    check("R2 oe low-cs", sdo_oe, 1);
    check("R3 first bit", sdo, st[0]);
    for (int k = 0; k < n; k++) begin
      sclk = 1'b1;
      sdi = (k < 16) ? word[k] : 1'b0;
      wait_cyc(HALF);
      if (k < 16) rd[k] = sdo;
      sclk = 1'b0;
      wait_cyc(HALF);
      if (k < 16 && sdo !== rd[k]) rd_err++;
    end
    cs_n = 1'b1;
    wait_cyc(2 * HALF);
    if (n == 16) begin
      exp_ctrl = word & 16'hFFFE;
      if (word[0]) exp_pulses++;
    end
  endtask

  initial begin
    logic [15:0] rd;
    int err;
    wait_cyc(3);
    check("R1 ctrl reset", ctrl_word, 16'hE000);
    check("R1 oe reset", sdo_oe, 0);
    check("R1 pulse reset", sreset_pulse, 0);
    rst_n = 1'b1;
    exp_ctrl = 16'hE000;
    wait_cyc(5);
    check("R2 oe idle", sdo_oe, 0);
    check("R2 sdo idle", sdo, 0);

    frame(16'h1AB6, 16, 16'hC35A, 0, rd, err);
    check("R6 commit", ctrl_word, exp_ctrl);
    check("R5 lsb first", ctrl_word, 16'h1AB6);
    check("R4 readback", rd, 16'hC35A);
    check("R4 hold", err, 0);
    check("R8 no pulse", pulse_cnt, exp_pulses);
    check("R2 oe released", sdo_oe, 0);

    frame(16'h6E03, 16, 16'h0001, 0, rd, err);
    check("R8 bit0 cleared", ctrl_word, exp_ctrl);
    check("R8 pulse count", pulse_cnt, exp_pulses);
    check("R8 pulse width", pulse_long, 0);
    check("R4 readback2", rd, 16'h0001);

    frame(16'hFFFF, 0, 16'h0001, 0, rd, err);
    check("R7 short read", ctrl_word, exp_ctrl);
    frame(16'hFFFF, 15, 16'hA5A5, 0, rd, err);
    check("R7 fifteen", ctrl_word, exp_ctrl);
    check("R4 readback15", rd[14:0], 15'h25A5);
    frame(16'h0F0F, 17, 16'h1234, 0, rd, err);
    check("R7 seventeen", ctrl_word, exp_ctrl);
    check("R8 no pulse bad frames", pulse_cnt, exp_pulses);

    frame(16'h9C38, 16, 16'h7E81, 1, rd, err);
    check("R9 status frozen", rd, 16'h7E81);
    check("R9 ctrl", ctrl_word, exp_ctrl);

    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; sdi = 1'b1; wait_cyc(HALF);
      sclk = 1'b0; sdi = 1'b0; wait_cyc(HALF);
    end
    check("R10 idle clocks ctrl", ctrl_word, exp_ctrl);
    check("R10 idle sdo", sdo, 0);
    frame(16'h2468, 16, 16'hBEEF, 0, rd, err);
    check("R10 next frame ctrl", ctrl_word, 16'h2468);
    check("R10 next frame read", rd, 16'hBEEF);
    check("R10 hold", err, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule